// File: doc/BRIEF.md
# Timer Match Action Controller

This block is a free-running timer with a bank of compare registers. A prescale counter divides the clock, and each time it wraps the timer count advances by one. Every compare register holds a value and three action bits. When the count equals the value on a timer tick, the block carries out whichever actions are enabled: it latches a sticky interrupt flag, returns the count to zero, or halts counting and drops the run enable.

Software drives the block through a flat register write port and a combinational read port. Through these it sets the prescale limit, the compare values, the packed action word and the run enable. It clears interrupt flags by writing ones to them. The block brings out the count, the per-compare flags, their OR, and the run enable. Intended uses are periodic tick generation, where a reset action sets the period, and one-shot delays, where a stop action ends the run.

Top module: `match_timer_ctrl`

## Requirements
- R1: After reset the count, prescale counter, run enable, all interrupt flags, the action word, the prescale limit and every compare value are zero.
- R2: While the run enable is 1, the prescale counter advances every clock. On the clock where it equals the prescale limit P, it wraps to 0 and the count advances by one, so the count steps once every P+1 enabled clocks. While the run enable is 0, neither counter changes.
- R3: Compare k owns action-word bits 3k (interrupt), 3k+1 (reset) and 3k+2 (stop). A timer tick taken while the count equals compare value k sets flag k when bit 3k is 1. With bit 3k at 0, flag k stays unchanged.
- R4: A tick taken while the count equals a compare value whose reset bit is set loads the count with 0 instead of value+1. With P=0 and compare value M, the count cycles through 0..M.
- R5: A tick taken while the count equals a compare value whose stop bit is set leaves the count at that value and clears the run enable. The run enable reads back as 0 on read address 0.
- R6: When a stop action and a reset action are both due on the same tick, from the same compare or from different ones, the stop wins and the count keeps its value.
- R7: When several compares hit on the same tick, all of their enabled flags set on that tick.
- R8: Flags are sticky. Writing address 3 clears exactly the flags whose data bits are 1. Reading address 3 returns the flags. Output `irq` is 1 when any flag is 1.
- R9: Action-word bits 31:21 (above bit 3N-1) are not stored. A write to them has no effect, and they read back as 0 on read address 1.
- R10: After a stop, the count keeps its stopped value until software writes 1 to bit 0 of address 0. Counting then resumes from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0 run enable, 1 action word, 2 prescale limit, 3 flag clear, 8+k compare k |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address, same map; 3 returns the flags |
| rd_data | output | 32 | Combinational read data, zero-extended |
| count | output | CNT_W | Timer count |
| irq_flags | output | N_MATCH | Sticky per-compare interrupt flags |
| irq | output | 1 | OR of all flags |
| cnt_enable | output | 1 | Current run enable |

## Verification
The bench sweeps four prescale limits against five reset-on-match periods. On every clock it compares the count with floor(k/(P+1)) mod (M+1), which tells an off-by-one in either counter apart from a wrong wrap point. Further patterns use the interrupt bits alone, interrupt bits on all seven compares at once, stop alone on an odd prescale, and stop and reset due together. Their results separate a wrong bit position, a missed simultaneous hit, a wrong priority, and a stop that fails to hold or to resume. Write patterns on the action word with only the reserved bits set, and with all bits set, show that bits above 20 neither store nor act.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ACT_BITS = 3;

   localparam logic [ADDR_W-1:0] REG_ENABLE = 4'd0;
   localparam logic [ADDR_W-1:0] REG_ACTION = 4'd1;
   localparam logic [ADDR_W-1:0] REG_PRESC  = 4'd2;
   localparam logic [ADDR_W-1:0] REG_FLAGS  = 4'd3;
   localparam logic [ADDR_W-1:0] REG_CMP0   = 4'd8;

   // one compare's action triple; field order matches bit order in the word
   typedef struct packed {
      logic halt;
      logic zero;
      logic flag;
   } cmp_act_t;
endpackage

// File: rtl/tmac_prescaler.sv
module tmac_prescaler #(
   parameter int unsigned PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] pc_q;

   assign tick = run && (pc_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (run) begin
         if (pc_q >= limit) pc_q <= '0;
         else               pc_q <= pc_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmac_match_bank.sv
module tmac_match_bank
   import tmac_pkg::*;
#(
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned ACT_W  = ACT_BITS * N_MATCH
) (
   input  logic [CNT_W-1:0]              count,
   input  logic                          tick,
   input  logic [N_MATCH-1:0][CNT_W-1:0] cmp_val,
   input  logic [ACT_W-1:0]              action,
   output logic [N_MATCH-1:0]            flag_hit,
   output logic                          zero_any,
   output logic                          halt_any
);
   logic [N_MATCH-1:0] zero_hit;
   logic [N_MATCH-1:0] halt_hit;

   for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
      cmp_act_t act;
      logic     eq;
      assign act         = action[ACT_BITS*k +: ACT_BITS];
      assign eq          = tick && (count == cmp_val[k]);
      assign flag_hit[k] = eq && act.flag;
      assign zero_hit[k] = eq && act.zero;
      assign halt_hit[k] = eq && act.halt;
   end

   assign zero_any = |zero_hit;
   assign halt_any = |halt_hit;
endmodule

// File: rtl/tmac_regs.sv
module tmac_regs
   import tmac_pkg::*;
#(
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PRE_W   = 8,
   localparam int unsigned ACT_W  = ACT_BITS * N_MATCH
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [DATA_W-1:0]             rd_data,
   input  logic                          halt_any,
   input  logic [N_MATCH-1:0]            flag_hit,
   output logic                          run_q,
   output logic [ACT_W-1:0]              action_q,
   output logic [PRE_W-1:0]              presc_q,
   output logic [N_MATCH-1:0][CNT_W-1:0] cmp_q,
   output logic [N_MATCH-1:0]            flags_q
);
   logic wr_run, wr_act, wr_pre, wr_clr;
   assign wr_run = wr_en && (wr_addr == REG_ENABLE);
   assign wr_act = wr_en && (wr_addr == REG_ACTION);
   assign wr_pre = wr_en && (wr_addr == REG_PRESC);
   assign wr_clr = wr_en && (wr_addr == REG_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         action_q <= '0;
         presc_q  <= '0;
         flags_q  <= '0;
      end else begin
         // a hardware halt outranks a same-cycle software enable
         if (halt_any)    run_q <= 1'b0;
         else if (wr_run) run_q <= wr_data[0];
         if (wr_act) action_q <= wr_data[ACT_W-1:0];
         if (wr_pre) presc_q  <= wr_data[PRE_W-1:0];
         // a new hit outranks a same-cycle clear
         flags_q <= (flags_q & ~(wr_clr ? wr_data[N_MATCH-1:0] : '0)) | flag_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else begin
         for (int k = 0; k < N_MATCH; k++) begin
            if (wr_en && (wr_addr == REG_CMP0 + ADDR_W'(k)))
               cmp_q[k] <= wr_data[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         REG_ENABLE: rd_data = DATA_W'(run_q);
         REG_ACTION: rd_data = DATA_W'(action_q);
         REG_PRESC:  rd_data = DATA_W'(presc_q);
         REG_FLAGS:  rd_data = DATA_W'(flags_q);
         default: begin
            for (int k = 0; k < N_MATCH; k++) begin
               if (rd_addr == REG_CMP0 + ADDR_W'(k)) rd_data = DATA_W'(cmp_q[k]);
            end
         end
      endcase
   end
endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
   import tmac_pkg::*;
#(
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PRE_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [3:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [3:0]         rd_addr,
   output logic [31:0]        rd_data,
   output logic [CNT_W-1:0]   count,
   output logic [N_MATCH-1:0] irq_flags,
   output logic               irq,
   output logic               cnt_enable
);
   localparam int unsigned ACT_W = ACT_BITS * N_MATCH;

   if (N_MATCH < 1 || N_MATCH > 8) begin : g_bad_n
      $error("N_MATCH must lie in 1..8 to fit the address map");
   end
   if (ACT_W > DATA_W) begin : g_bad_act
      $error("action word wider than the data bus");
   end
   if (CNT_W < 2 || CNT_W > DATA_W || PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_w
      $error("counter widths out of range");
   end

   logic                          run_q;
   logic [ACT_W-1:0]              action_q;
   logic [PRE_W-1:0]              presc_q;
   logic [N_MATCH-1:0][CNT_W-1:0] cmp_q;
   logic [N_MATCH-1:0]            flags_q;
   logic [N_MATCH-1:0]            flag_hit;
   logic                          zero_any, halt_any, tick;
   logic [CNT_W-1:0]              count_q;

   tmac_regs #(.N_MATCH(N_MATCH), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .halt_any(halt_any), .flag_hit(flag_hit),
      .run_q(run_q), .action_q(action_q), .presc_q(presc_q),
      .cmp_q(cmp_q), .flags_q(flags_q)
   );

   tmac_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .limit(presc_q), .tick(tick)
   );

   tmac_match_bank #(.N_MATCH(N_MATCH), .CNT_W(CNT_W)) u_bank (
      .count(count_q), .tick(tick), .cmp_val(cmp_q), .action(action_q),
      .flag_hit(flag_hit), .zero_any(zero_any), .halt_any(halt_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (tick && !halt_any) begin
         if (zero_any) count_q <= '0;
         else          count_q <= count_q + 1'b1;
      end
   end

   assign count      = count_q;
   assign irq_flags  = flags_q;
   assign irq        = |flags_q;
   assign cnt_enable = run_q;
endmodule

// File: rtl/tmac_checker.sv
module tmac_checker #(
   parameter int unsigned N_MATCH = 7,
   parameter int unsigned CNT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [3:0]         wr_addr,
   input logic [3:0]         rd_addr,
   input logic [31:0]        rd_data,
   input logic [CNT_W-1:0]   count,
   input logic               cnt_enable,
   input logic [N_MATCH-1:0] irq_flags,
   input logic [N_MATCH-1:0] flag_hit,
   input logic               zero_any,
   input logic               halt_any,
   input logic               tick
);
   localparam int unsigned ACT_W = 3 * N_MATCH;
   localparam logic [31:0] ACT_MASK = (ACT_W >= 32) ? '1 : ((32'd1 << ACT_W) - 32'd1);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_enable |=> $stable(count));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count != $past(count) |-> (count == CNT_W'($past(count) + 1'b1)) || (count == '0));

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_hit != '0 |=> (irq_flags & $past(flag_hit)) == $past(flag_hit));

   p_zero_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick && zero_any && !halt_any |=> count == '0);

   p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      halt_any |=> !cnt_enable && $stable(count));

   p_halt_over_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halt_any && zero_any |=> count == $past(count));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 4'd3) |=> (irq_flags & $past(irq_flags)) == $past(irq_flags));

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == 4'd1 |-> (rd_data & ~ACT_MASK) == '0);
endmodule

bind match_timer_ctrl tmac_checker #(.N_MATCH(N_MATCH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rd_addr(rd_addr), .rd_data(rd_data), .count(count),
   .cnt_enable(cnt_enable), .irq_flags(irq_flags), .flag_hit(flag_hit),
   .zero_any(zero_any), .halt_any(halt_any), .tick(tick)
);

// File: tb/tb_match_timer_ctrl.sv
`timescale 1ns/1ps
module tb_match_timer_ctrl;
   localparam int N = 7;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [3:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic [CW-1:0] count;
   logic [N-1:0]  irq_flags;
   logic          irq;
   logic          cnt_enable;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   match_timer_ctrl #(.N_MATCH(N), .CNT_W(CW), .PRE_W(8)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .count(count), .irq_flags(irq_flags), .irq(irq), .cnt_enable(cnt_enable)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      do_reset();
      // R1 reset state
      chk("R1 count", 32'(count), 0);
      chk("R1 flags", 32'(irq_flags), 0);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 enable", 32'(cnt_enable), 0);
      rd(4'd1, v); chk("R1 action", v, 0);
      rd(4'd2, v); chk("R1 prescale", v, 0);
      rd(4'd8, v); chk("R1 cmp0", v, 0);
      rd(4'd14, v); chk("R1 cmp6", v, 0);

      // R2 / R4 sweep: period from prescale and reset-on-match on compare 0
      for (int p = 0; p < 4; p++) begin
         for (int m = 1; m <= 5; m++) begin
            do_reset();
            wr(4'd2, 32'(p));
            wr(4'd8, 32'(m));
            wr(4'd1, 32'h2);
            wr(4'd0, 32'h1);
            for (int k = 1; k <= (p + 1) * (m + 1) * 2 + 3; k++) begin
               edges(1);
               chk("R2 R4 count sweep", 32'(count), 32'((k / (p + 1)) % (m + 1)));
            end
            wr(4'd0, 32'h0);
            v = 32'(count);
            edges(5);
            chk("R2 idle hold", 32'(count), v);
         end
      end

      // R3 interrupt bits on compare 0 and 6, none on compare 1
      do_reset();
      wr(4'd8, 32'd3); wr(4'd9, 32'd3); wr(4'd14, 32'd3);
      wr(4'd1, 32'h0004_0001);
      wr(4'd0, 32'h1);
      edges(3);
      chk("R3 no flag before hit", 32'(irq_flags), 0);
      edges(1);
      chk("R3 flags at hit", 32'(irq_flags), 32'h41);
      chk("R3 irq at hit", 32'(irq), 1);
      wr(4'd0, 32'h0);
      // R8 sticky and write-one-to-clear
      edges(4);
      chk("R8 sticky", 32'(irq_flags), 32'h41);
      rd(4'd3, v); chk("R8 flag readback", v, 32'h41);
      wr(4'd3, 32'h01);
      chk("R8 partial clear", 32'(irq_flags), 32'h40);
      chk("R8 irq still high", 32'(irq), 1);
      wr(4'd3, 32'h40);
      chk("R8 full clear", 32'(irq_flags), 0);
      chk("R8 irq low", 32'(irq), 0);

      // R7 all compares hit together
      do_reset();
      for (int k = 0; k < N; k++) wr(4'(8 + k), 32'd2);
      wr(4'd1, 32'h0004_9249);
      wr(4'd0, 32'h1);
      edges(2);
      chk("R7 before hit", 32'(irq_flags), 0);
      edges(1);
      chk("R7 all flags", 32'(irq_flags), 32'h7F);

      // R5 stop on compare 1 with prescale 1, then R10 resume
      do_reset();
      wr(4'd2, 32'd1);
      wr(4'd9, 32'd4);
      wr(4'd1, 32'h20);
      wr(4'd0, 32'h1);
      edges(9);
      chk("R5 count before stop", 32'(count), 4);
      chk("R5 enable before stop", 32'(cnt_enable), 1);
      edges(1);
      chk("R5 count held", 32'(count), 4);
      chk("R5 enable cleared", 32'(cnt_enable), 0);
      edges(20);
      chk("R10 count stays stopped", 32'(count), 4);
      rd(4'd0, v); chk("R5 enable readback", v, 0);
      wr(4'd1, 32'h0);
      edges(3);
      chk("R10 no resume without enable", 32'(count), 4);
      wr(4'd0, 32'h1);
      chk("R10 resume first", 32'(count), 4);
      edges(1);
      chk("R10 resume mid", 32'(count), 4);
      edges(1);
      chk("R10 resumed advance", 32'(count), 5);

      // R6 stop beats reset: same compare, then different compares
      do_reset();
      wr(4'd8, 32'd3);
      wr(4'd1, 32'h6);
      wr(4'd0, 32'h1);
      edges(10);
      chk("R6 same compare count", 32'(count), 3);
      chk("R6 same compare enable", 32'(cnt_enable), 0);
      do_reset();
      wr(4'd10, 32'd3); wr(4'd11, 32'd3);
      wr(4'd1, 32'h0000_0880);
      wr(4'd0, 32'h1);
      edges(10);
      chk("R6 split compares count", 32'(count), 3);
      chk("R6 split compares enable", 32'(cnt_enable), 0);

      // R9 reserved action bits
      do_reset();
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, v); chk("R9 all ones readback", v, 32'h001F_FFFF);
      wr(4'd1, 32'hFFE0_0000);
      rd(4'd1, v); chk("R9 reserved only readback", v, 0);
      wr(4'd0, 32'h1);
      edges(5);
      chk("R9 reserved bits no action count", 32'(count), 5);
      chk("R9 reserved bits no flags", 32'(irq_flags), 0);
      chk("R9 reserved bits no stop", 32'(cnt_enable), 1);

      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule